// File: doc/BRIEF.md
# Multicycle Seven-Instruction 32-bit Processor Core

This core executes a small subset of a 32-bit load/store instruction set. It has one memory port that carries both instruction fetches and data accesses. Every instruction begins with a fetch cycle. In that cycle the program counter drives the address bus and the returned word is captured into an instruction register. One to three execute cycles follow. In these cycles a controller sets the datapath control points: operand selects, immediate use, register write, PC load, the source of the shared address bus, the source of the shared data bus, and the memory write strobe.

The datapath holds a 32-entry by 32-bit register file, the program counter, the instruction register, a memory data register, an adder/subtractor and an equality/sign comparator. One internal data bus feeds the instruction register, the register file write port, the memory write data and the jump paths. A controller state machine decides which source drives it in each cycle. Memory is external and is expected to return read data combinationally for the address it is given.

Instruction fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], imm16 [15:0], target [25:0].

Top module: `tcpu_core`

## Requirements
- R1: While rst_ni is low and on release, the PC is 0, the controller is in its fetch state, mem_we_o is 0 and mem_addr_o is 0.
- R2: Each instruction starts with a fetch cycle in which mem_addr_o equals the PC, mem_we_o is 0, and the word on mem_rdata_i is taken into the instruction register.
- R3: With opcode 0, funct 0x21 writes rs+rt into rd and funct 0x23 writes rs-rt into rd. Each takes 2 cycles and advances the PC by 4.
- R4: Opcode 0x23 takes 4 cycles. In its third cycle mem_addr_o is rs plus the sign-extended imm16 and mem_we_o is 0. The word read there is written into rt, and the PC advances by 4.
- R5: Opcode 0x2B takes 3 cycles. In its third cycle mem_addr_o is rs plus the sign-extended imm16, mem_we_o is 1 and mem_wdata_o is rt. The PC advances by 4.
- R6: Opcode 0x02 takes 2 cycles and sets the PC to {PC[31:28], target, 2'b00}.
- R7: Opcode 0 with funct 0x08 takes 2 cycles and sets the PC to rs.
- R8: Opcode 0x04 takes 2 cycles. When rs equals rt, the PC becomes PC+4+(sign-extended imm16 shifted left 2). Otherwise it becomes PC+4.
- R9: Opcode 0x01 with rt=0 takes 2 cycles. When rs bit 31 is 1, the PC becomes PC+4+(sign-extended imm16 shifted left 2). Otherwise it becomes PC+4.
- R10: Register 0 always reads as 0. Writes that target it have no effect.
- R11: Any other opcode/funct combination, including opcode 0x01 with rt≠0, takes 2 cycles, writes nothing and only advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_addr_o | output | 32 | Shared memory byte address (PC or computed address) |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 32 | Memory write data (driven from the internal data bus) |
| mem_rdata_i | input | 32 | Combinational memory read data |

## Verification
A wrong PC, a wrong register value or a wrong FSM state shows up on the memory port within a few cycles. A PC error appears at the very next fetch address. A register error appears at the next load or store address that uses the register, or in the next stored data word. A branch decision error appears as a fetch address that skips or lands on the wrong word. A state sequencing error shifts the cycle in which a data address or a write strobe appears. Stores are placed directly after each kind of control transfer, so a wrong decision leaves a visible trace in memory.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;
  localparam int unsigned XLEN = 32;

  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_REGIMM  = 6'h01;
  localparam logic [5:0] OP_J       = 6'h02;
  localparam logic [5:0] OP_BEQ     = 6'h04;
  localparam logic [5:0] OP_LW      = 6'h23;
  localparam logic [5:0] OP_SW      = 6'h2B;
  localparam logic [5:0] FN_JR      = 6'h08;
  localparam logic [5:0] FN_ADDU    = 6'h21;
  localparam logic [5:0] FN_SUBU    = 6'h23;

  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_MEM, ST_WB} state_e;
  typedef enum logic [1:0] {NPC_INC, NPC_BRANCH, NPC_BUS} npc_e;
  typedef enum logic [0:0] {ADR_PC, ADR_SUM} adr_e;
  typedef enum logic [2:0] {DB_MEM, DB_SUM, DB_RB, DB_RA, DB_JTGT, DB_MDR} dbus_e;
  typedef enum logic [3:0] {
    IC_ADDU, IC_SUBU, IC_LW, IC_SW, IC_J, IC_JR, IC_BEQ, IC_BLTZ, IC_NOP
  } iclass_e;

  typedef struct packed {
    logic  ir_ld;
    logic  pc_ld;
    npc_e  npc_sel;
    logic  rf_we;
    logic  dst_rd;
    logic  b_imm;
    logic  alu_sub;
    adr_e  adr_sel;
    dbus_e db_sel;
    logic  mem_we;
    logic  mdr_ld;
  } ctrl_t;
endpackage

// File: rtl/tcpu_decode.sv
module tcpu_decode
  import tcpu_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  input  logic [4:0] rt_i,
  output iclass_e    cls_o
);
  always_comb begin
    cls_o = IC_NOP;
    case (op_i)
      OP_SPECIAL: begin
        case (funct_i)
          FN_ADDU: cls_o = IC_ADDU;
          FN_SUBU: cls_o = IC_SUBU;
          FN_JR:   cls_o = IC_JR;
          default: cls_o = IC_NOP;
        endcase
      end
      OP_REGIMM: cls_o = (rt_i == 5'd0) ? IC_BLTZ : IC_NOP;
      OP_J:      cls_o = IC_J;
      OP_BEQ:    cls_o = IC_BEQ;
      OP_LW:     cls_o = IC_LW;
      OP_SW:     cls_o = IC_SW;
      default:   cls_o = IC_NOP;
    endcase
  end
endmodule

// File: rtl/tcpu_regfile.sv
module tcpu_regfile #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_addr_i,
  input  logic [AW-1:0] rb_addr_i,
  output logic [W-1:0]  ra_o,
  output logic [W-1:0]  rb_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i
);
  logic [W-1:0] regs_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign ra_o = (ra_addr_i == '0) ? '0 : regs_q[ra_addr_i];
  assign rb_o = (rb_addr_i == '0) ? '0 : regs_q[rb_addr_i];

  // R10
  rf_zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i == '0) |=> (regs_q[0] == '0));

  // R3
  rf_write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0) |=> (regs_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/tcpu_alu.sv
module tcpu_alu #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] cmp_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         eq_o,
  output logic         neg_o
);
  assign sum_o = sub_i ? (a_i - b_i) : (a_i + b_i);
  assign eq_o  = (a_i == cmp_i);
  assign neg_o = a_i[W-1];
endmodule

// File: rtl/tcpu_ctrl.sv
module tcpu_ctrl
  import tcpu_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  iclass_e cls_i,
  input  logic    eq_i,
  input  logic    neg_i,
  output ctrl_t   ctl_o,
  output state_e  state_o
);
  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  always_comb begin
    ctl_o   = '0;
    state_d = state_q;
    case (state_q)
      ST_FETCH: begin
        ctl_o.adr_sel = ADR_PC;
        ctl_o.db_sel  = DB_MEM;
        ctl_o.ir_ld   = 1'b1;
        state_d       = ST_EXEC;
      end
      ST_EXEC: begin
        state_d       = ST_FETCH;
        ctl_o.pc_ld   = 1'b1;
        ctl_o.npc_sel = NPC_INC;
        case (cls_i)
          IC_ADDU, IC_SUBU: begin
            ctl_o.alu_sub = (cls_i == IC_SUBU);
            ctl_o.db_sel  = DB_SUM;
            ctl_o.rf_we   = 1'b1;
            ctl_o.dst_rd  = 1'b1;
          end
          IC_J: begin
            ctl_o.db_sel  = DB_JTGT;
            ctl_o.npc_sel = NPC_BUS;
          end
          IC_JR: begin
            ctl_o.db_sel  = DB_RA;
            ctl_o.npc_sel = NPC_BUS;
          end
          IC_BEQ:  ctl_o.npc_sel = eq_i  ? NPC_BRANCH : NPC_INC;
          IC_BLTZ: ctl_o.npc_sel = neg_i ? NPC_BRANCH : NPC_INC;
          IC_LW, IC_SW: begin
            ctl_o.pc_ld = 1'b0;
            ctl_o.b_imm = 1'b1;
            state_d     = ST_MEM;
          end
          default: ;
        endcase
      end
      ST_MEM: begin
        ctl_o.b_imm   = 1'b1;
        ctl_o.adr_sel = ADR_SUM;
        if (cls_i == IC_SW) begin
          ctl_o.db_sel  = DB_RB;
          ctl_o.mem_we  = 1'b1;
          ctl_o.pc_ld   = 1'b1;
          ctl_o.npc_sel = NPC_INC;
          state_d       = ST_FETCH;
        end else begin
          ctl_o.db_sel = DB_MEM;
          ctl_o.mdr_ld = 1'b1;
          state_d      = ST_WB;
        end
      end
      ST_WB: begin
        ctl_o.db_sel  = DB_MDR;
        ctl_o.rf_we   = 1'b1;
        ctl_o.pc_ld   = 1'b1;
        ctl_o.npc_sel = NPC_INC;
        state_d       = ST_FETCH;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  assign state_o = state_q;

  // R2
  fetch_then_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH) |=> (state_q == ST_EXEC));

  // R4
  wb_after_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WB) |-> ($past(state_q) == ST_MEM));
endmodule

// File: rtl/tcpu_core.sv
module tcpu_core
  import tcpu_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter int unsigned NREGS    = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [31:0] mem_addr_o,
  output logic        mem_we_o,
  output logic [31:0] mem_wdata_o,
  input  logic [31:0] mem_rdata_i
);
  localparam int unsigned W  = XLEN;
  localparam int unsigned AW = $clog2(NREGS);

  logic [W-1:0] pc_q, ir_q, mdr_q;
  logic [W-1:0] ra, rb, sext, alu_b, sum, pc_inc, br_tgt, jmp_tgt, dbus, pc_d;
  logic         eq, neg;
  logic [AW-1:0] waddr;
  ctrl_t   ctl;
  state_e  state;
  iclass_e cls;

  tcpu_decode u_decode (
    .op_i    (ir_q[31:26]),
    .funct_i (ir_q[5:0]),
    .rt_i    (ir_q[20:16]),
    .cls_o   (cls)
  );

  tcpu_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cls_i   (cls),
    .eq_i    (eq),
    .neg_i   (neg),
    .ctl_o   (ctl),
    .state_o (state)
  );

  assign waddr = ctl.dst_rd ? ir_q[15:11] : ir_q[20:16];

  tcpu_regfile #(.NREGS(NREGS), .W(W)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ra_addr_i (ir_q[25:21]),
    .rb_addr_i (ir_q[20:16]),
    .ra_o      (ra),
    .rb_o      (rb),
    .we_i      (ctl.rf_we),
    .waddr_i   (waddr),
    .wdata_i   (dbus)
  );

  assign sext  = {{(W-16){ir_q[15]}}, ir_q[15:0]};
  assign alu_b = ctl.b_imm ? sext : rb;

  tcpu_alu #(.W(W)) u_alu (
    .a_i   (ra),
    .b_i   (alu_b),
    .cmp_i (rb),
    .sub_i (ctl.alu_sub),
    .sum_o (sum),
    .eq_o  (eq),
    .neg_o (neg)
  );

  assign pc_inc  = pc_q + 32'd4;
  assign br_tgt  = pc_inc + {sext[W-3:0], 2'b00};
  assign jmp_tgt = {pc_q[31:28], ir_q[25:0], 2'b00};

  // shared data bus
  always_comb begin
    case (ctl.db_sel)
      DB_MEM:  dbus = mem_rdata_i;
      DB_SUM:  dbus = sum;
      DB_RB:   dbus = rb;
      DB_RA:   dbus = ra;
      DB_JTGT: dbus = jmp_tgt;
      DB_MDR:  dbus = mdr_q;
      default: dbus = '0;
    endcase
  end

  always_comb begin
    case (ctl.npc_sel)
      NPC_BRANCH: pc_d = br_tgt;
      NPC_BUS:    pc_d = dbus;
      default:    pc_d = pc_inc;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= RESET_PC;
      ir_q  <= '0;
      mdr_q <= '0;
    end else begin
      if (ctl.pc_ld)  pc_q  <= pc_d;
      if (ctl.ir_ld)  ir_q  <= dbus;
      if (ctl.mdr_ld) mdr_q <= dbus;
    end
  end

  assign mem_addr_o  = (ctl.adr_sel == ADR_SUM) ? sum : pc_q;
  assign mem_we_o    = ctl.mem_we;
  assign mem_wdata_o = dbus;

  // R5
  we_only_in_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (state == ST_MEM));

  // R2
  pc_moves_into_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_q != $past(pc_q)) |-> (state == ST_FETCH));

  // R2
  ir_loads_after_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_q != $past(ir_q)) |-> ($past(state) == ST_FETCH));

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (pc_q == RESET_PC && state == ST_FETCH && !mem_we_o));
endmodule

// File: tb/tcpu_core_tb.sv
module tcpu_core_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        mem_we_o;

  logic [31:0] ram   [256];
  logic [31:0] m_mem [256];
  logic [31:0] m_rf  [32];
  logic [31:0] m_pc, m_ir, m_ld;
  int          m_phase;
  string       m_tag;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #2 clk_i = ~clk_i;

  tcpu_core u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i)
  );

  assign mem_rdata_i = ram[mem_addr_o[9:2]];
  always @(posedge clk_i) if (mem_we_o) ram[mem_addr_o[9:2]] <= mem_wdata_o;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(logic [31:0] ir);
    case (ir[31:26])
      6'h00:   return (ir[5:0] == 6'h21 || ir[5:0] == 6'h23) ? "R3" :
                      (ir[5:0] == 6'h08) ? "R7" : "R11";
      6'h01:   return (ir[20:16] == 5'd0) ? "R9" : "R11";
      6'h02:   return "R6";
      6'h04:   return "R8";
      6'h23:   return "R4";
      6'h2B:   return "R5";
      default: return "R11";
    endcase
  endfunction

  // behavioural ISA model stepped once per clock
  task automatic model_step();
    logic [5:0]  op = m_ir[31:26];
    logic [5:0]  fn = m_ir[5:0];
    logic [31:0] rs = m_rf[m_ir[25:21]];
    logic [31:0] rt = m_rf[m_ir[20:16]];
    logic [31:0] sx = {{16{m_ir[15]}}, m_ir[15:0]};
    logic [31:0] ea = rs + sx;
    case (m_phase)
      0: begin
        chk(mem_addr_o == m_pc, m_tag, "fetch address (R2)", mem_addr_o, m_pc);
        chk(mem_we_o == 1'b0, "R2", "fetch write strobe", {31'd0, mem_we_o}, 32'd0);
        m_ir    = m_mem[m_pc[9:2]];
        m_phase = 1;
      end
      1: begin
        chk(mem_we_o == 1'b0, tag_of(m_ir), "exec write strobe", {31'd0, mem_we_o}, 32'd0);
        m_tag = tag_of(m_ir);
        if (op == 6'h23 || op == 6'h2B) m_phase = 2;
        else begin
          m_phase = 0;
          if (op == 6'h00 && fn == 6'h21) begin
            if (m_ir[15:11] != 0) m_rf[m_ir[15:11]] = rs + rt;
            m_pc += 4;
          end else if (op == 6'h00 && fn == 6'h23) begin
            if (m_ir[15:11] != 0) m_rf[m_ir[15:11]] = rs - rt;
            m_pc += 4;
          end else if (op == 6'h00 && fn == 6'h08) m_pc = rs;
          else if (op == 6'h02) m_pc = {m_pc[31:28], m_ir[25:0], 2'b00};
          else if (op == 6'h04) m_pc = (rs == rt) ? m_pc + 4 + (sx << 2) : m_pc + 4;
          else if (op == 6'h01 && m_ir[20:16] == 0)
            m_pc = rs[31] ? m_pc + 4 + (sx << 2) : m_pc + 4;
          else m_pc += 4;
        end
      end
      2: begin
        chk(mem_addr_o == ea, m_tag, "data address", mem_addr_o, ea);
        chk(mem_we_o == (op == 6'h2B), m_tag, "data write strobe", {31'd0, mem_we_o},
            {31'd0, op == 6'h2B});
        if (op == 6'h2B) begin
          chk(mem_wdata_o == rt, "R5", "store data", mem_wdata_o, rt);
          m_mem[ea[9:2]] = rt;
          m_pc += 4;
          m_phase = 0;
        end else begin
          m_ld    = m_mem[ea[9:2]];
          m_phase = 3;
        end
      end
      default: begin
        chk(mem_we_o == 1'b0, "R4", "writeback strobe", {31'd0, mem_we_o}, 32'd0);
        if (m_ir[20:16] != 0) m_rf[m_ir[20:16]] = m_ld;
        m_pc += 4;
        m_phase = 0;
      end
    endcase
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 32'h0;
    ram[0]  = enc_i(6'h23, 0, 1, 16'h0200);
    ram[1]  = enc_i(6'h23, 0, 2, 16'h0204);
    ram[2]  = enc_r(1, 2, 3, 6'h21);
    ram[3]  = enc_r(1, 2, 4, 6'h23);
    ram[4]  = enc_r(1, 1, 0, 6'h21);
    ram[5]  = enc_i(6'h2B, 0, 3, 16'h0208);
    ram[6]  = enc_i(6'h2B, 0, 0, 16'h020C);
    ram[7]  = enc_i(6'h04, 1, 1, 16'h0001);
    ram[8]  = enc_i(6'h2B, 0, 1, 16'h0210);
    ram[9]  = enc_i(6'h04, 1, 2, 16'h0005);
    ram[10] = enc_i(6'h01, 2, 0, 16'h0001);
    ram[11] = enc_i(6'h2B, 0, 1, 16'h0210);
    ram[12] = enc_i(6'h01, 1, 0, 16'h0005);
    ram[13] = {6'h02, 26'd16};
    ram[14] = enc_i(6'h2B, 0, 1, 16'h0210);
    ram[15] = enc_i(6'h2B, 0, 1, 16'h0210);
    ram[16] = enc_i(6'h23, 0, 6, 16'h0214);
    ram[17] = enc_i(6'h2B, 6, 4, 16'hFFFC);
    ram[18] = enc_i(6'h3F, 1, 5, 16'h0000);
    ram[19] = enc_i(6'h23, 0, 7, 16'h0218);
    ram[20] = enc_r(7, 0, 0, 6'h08);
    ram[21] = enc_i(6'h2B, 0, 1, 16'h0210);
    ram[22] = enc_i(6'h01, 1, 3, 16'h0002);
    ram[23] = enc_i(6'h04, 0, 0, 16'hFFFF);
    ram[128] = 32'd5;
    ram[129] = 32'hFFFF_FFFD;
    ram[131] = 32'hDEAD_BEEF;
    ram[132] = 32'h0000_1111;
    ram[133] = 32'h0000_0220;
    ram[134] = 32'h0000_0058;
    for (int i = 0; i < 256; i++) m_mem[i] = ram[i];
    for (int i = 0; i < 32; i++) m_rf[i] = 32'h0;
    m_pc = 32'h0; m_ir = 32'h0; m_ld = 32'h0; m_phase = 0; m_tag = "R1";

    repeat (3) begin
      @(negedge clk_i);
      chk(mem_we_o == 1'b0, "R1", "reset write strobe", {31'd0, mem_we_o}, 32'd0);
      chk(mem_addr_o == 32'h0, "R1", "reset address", mem_addr_o, 32'h0);
    end
    rst_ni = 1'b1;
    for (int c = 0; c < 400; c++) begin
      model_step();
      @(negedge clk_i);
    end

    chk(ram[130] == 32'd2, "R3", "addu result stored", ram[130], 32'd2);
    chk(ram[131] == 32'd0, "R10", "r0 stored after write attempt", ram[131], 32'd0);
    chk(ram[132] == 32'h1111, "R8", "skipped stores after taken transfers", ram[132], 32'h1111);
    chk(ram[135] == 32'd8, "R5", "subu result via negative offset store", ram[135], 32'd8);
    for (int i = 0; i < 256; i++)
      chk(ram[i] == m_mem[i], "R4", $sformatf("memory word %0d", i), ram[i], m_mem[i]);
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule